// File: doc/BRIEF.md
# Instruction Fetch Breakpoint Sequencer

This block is one breakpoint channel that watches the instruction fetch stream for a programmed address and asks the debug logic to stop the processor at the right instruction boundary. Each fetch is compared against the break address when it is fetched. The result travels with the instruction as a one-bit flag in a small slot queue, indexed by a tag. The flag is only acted on when the execute stage reports that the instruction with that tag has really executed. A flush drops every flag in flight, so wrong-path fetches taken at a branch or an interrupt transition can never stop the machine.

A control bit picks the break point. In pre mode the request is raised for the matching instruction itself, so the exception logic can stop before it takes effect. In post mode the matching instruction completes and the request is raised at the next instruction that can accept a break. Delay-slot instructions cannot accept a break, so a post break set on a delayed branch moves past its slot. The two forbidden set-ups are silently dropped: a pre break on a delay-slot instruction, and a post break on a SLEEP instruction.

The sequencer has three states. `BS_IDLE` waits for a flagged retire. `BS_ARMED` holds a post break until an instruction that accepts it retires. `BS_FIRE` drives the one-cycle request. The transitions are:
- idle-to-fire: a flagged pre-mode retire that is not in a delay slot.
- idle-to-armed: a flagged post-mode retire that is not SLEEP.
- idle-hold: the suppressed cases, and any other cycle.
- armed-to-fire: a retire outside a delay slot.
- armed-hold: delay-slot retires and idle cycles.
- fire-to-idle: always, after one cycle.
- any-to-idle: whenever the channel is disabled.

Top module: `ifbrk_top`

## Requirements
- R1: After reset `brk_req` is 0 and the queue holds no flags, so a retire of any tag gives no break.
- R2: A fetch matches when `fetch_addr` equals `cfg_addr` in every bit except bit 0, which is ignored because instructions are halfword aligned.
- R3: With `cfg_post`=0, a retire strobe that carries a flagged tag and has `ex_dslot`=0 makes `brk_req` high in the cycle after that clock edge.
- R4: With `cfg_post`=1, a flagged retire gives no request itself. `brk_req` goes high in the cycle after the next retire strobe that has `ex_dslot`=0.
- R5: While a post break is pending, retires with `ex_dslot`=1 do not fire it. The break waits for the first later retire with `ex_dslot`=0.
- R6: `flush` clears all flags, including the flag of a fetch in the same cycle. It also restarts tag numbering at 0, so a later retire of a flushed tag gives no break.
- R7: Tags are assigned in fetch order, starting at 0 after reset or flush and wrapping modulo DEPTH. A retire looks up only the slot named by `ex_tag` and then empties that slot, so a second retire of the same tag gives no break.
- R8: In pre mode, a flagged retire with `ex_dslot`=1 is dropped: no request follows, and nothing is left pending.
- R9: In post mode, a flagged retire with `ex_sleep`=1 is dropped, and nothing is left pending.
- R10: With `cfg_enable`=0 no request is raised and any pending post break is discarded. Fetches made while the channel is disabled are never flagged.
- R11: `brk_req` is high for one cycle at a time and is always followed by a low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_post | input | 1 | 0 = break before the instruction, 1 = break after it |
| cfg_addr | input | AW | Break address |
| fetch_valid | input | 1 | An instruction fetch happens this cycle |
| fetch_addr | input | AW | Address of the fetch |
| flush | input | 1 | Discard all fetched instructions in flight |
| ex_retire | input | 1 | An instruction is confirmed executed this cycle |
| ex_tag | input | $clog2(DEPTH) | Tag of the executed instruction |
| ex_dslot | input | 1 | Executed instruction sits in a delay slot |
| ex_sleep | input | 1 | Executed instruction is SLEEP |
| brk_req | output | 1 | One-cycle break request |

## Verification
The bench checks the following corner cases, and what a faulty design would do in each:
- A post break on a delayed branch, where the following delay-slot retire must not fire. A design that fires on any retire would break one instruction early.
- A fetch and a flush in the same cycle, and tags reused after a flush. A queue that lets the fetch win, or that keeps its write pointer, would break on a discarded instruction.
- Out-of-order lookup by tag, and a second retire of the same tag. These expose a design that reads the queue head or never empties a slot.
- The two suppressed set-ups and a disable while a break is armed. These catch a design that leaves a stale break pending, which would then fire on an unrelated instruction.

// File: rtl/ifbrk_pkg.sv
package ifbrk_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_ARMED = 2'd1,
        BS_FIRE  = 2'd2
    } brk_state_e;

endpackage

// File: rtl/ifbrk_match.sv
module ifbrk_match #(
    parameter int AW         = 32,
    parameter int ALIGN_BITS = 1
) (
    input  logic [AW-1:0] fetch_addr,
    input  logic [AW-1:0] cfg_addr,
    input  logic          enable,
    output logic          hit
);
    // Low address bits below the instruction alignment do not take part
    localparam logic [AW-1:0] CMP_MASK = ~((AW'(1) << ALIGN_BITS) - AW'(1));

    logic [AW-1:0] diff;

    always_comb begin
        diff = (fetch_addr ^ cfg_addr) & CMP_MASK;
        hit  = enable && (diff == '0);
    end

endmodule

// File: rtl/ifbrk_tagq.sv
module ifbrk_tagq #(
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     push_hit,
    input  logic                     flush,
    input  logic                     pop,
    input  logic [$clog2(DEPTH)-1:0] pop_tag,
    output logic                     pop_hit
);
    localparam int TW = $clog2(DEPTH);

    logic [DEPTH-1:0] slot_v;
    logic [DEPTH-1:0] slot_f;
    logic [TW-1:0]    wr_ptr;

    // Write pointer: the tag that the next fetch receives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
        end else if (push) begin
            wr_ptr <= wr_ptr + TW'(1);
        end
    end

    // One flag slot per tag
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_v[i] <= 1'b0;
                slot_f[i] <= 1'b0;
            end else if (flush) begin
                slot_v[i] <= 1'b0;
                slot_f[i] <= 1'b0;
            end else if (push && (wr_ptr == TW'(i))) begin
                slot_v[i] <= 1'b1;
                slot_f[i] <= push_hit;
            end else if (pop && (pop_tag == TW'(i))) begin
                slot_v[i] <= 1'b0;
                slot_f[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        pop_hit = pop && slot_v[pop_tag] && slot_f[pop_tag];
    end

    // R6: after a flush no slot holds an instruction
    a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (slot_v == '0));

    // R6: the tag numbering restarts after a flush
    a_r6_ptr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (wr_ptr == '0));

    // R7: a retired slot is emptied unless a fetch refills it in the same cycle
    a_r7_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush && !(push && (wr_ptr == pop_tag)))
        |=> !slot_v[$past(pop_tag)]);

endmodule

// File: rtl/ifbrk_seq.sv
module ifbrk_seq
    import ifbrk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic post,
    input  logic ret_valid,
    input  logic ret_hit,
    input  logic ret_dslot,
    input  logic ret_sleep,
    output logic brk_req
);
    brk_state_e state;
    brk_state_e nxt;
    brk_state_e launch;

    // Where a flagged retire leads from rest
    always_comb begin
        launch = BS_IDLE;
        if (ret_hit) begin
            if (!post) begin
                launch = ret_dslot ? BS_IDLE : BS_FIRE;
            end else begin
                launch = ret_sleep ? BS_IDLE : BS_ARMED;
            end
        end
    end

    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = BS_IDLE;
        end else begin
            unique case (state)
                BS_IDLE:  nxt = launch;
                BS_ARMED: nxt = (ret_valid && !ret_dslot) ? BS_FIRE : BS_ARMED;
                BS_FIRE:  nxt = BS_IDLE;
                default:  nxt = BS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BS_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Outputs
    always_comb begin
        brk_req = (state == BS_FIRE);
    end

    // R11: the request never lasts more than one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !brk_req);

    // R10: a disabled channel is silent in the next cycle
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !brk_req);

    // R3: a flagged pre-mode retire outside a delay slot fires next cycle
    a_r3_pre_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == BS_IDLE && ret_hit && !post && !ret_dslot) |=> brk_req);

    // R8: a pre break on a delay-slot instruction is dropped
    a_r8_pre_dslot_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state != BS_ARMED && ret_hit && !post && ret_dslot) |=> !brk_req);

    // R9: a post break on SLEEP leaves nothing pending
    a_r9_post_sleep_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == BS_IDLE && ret_hit && post && ret_sleep) |=> (state == BS_IDLE));

    // R5: delay-slot retires keep a post break waiting
    a_r5_dslot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == BS_ARMED && ret_valid && ret_dslot) |=> (state == BS_ARMED));

    // R4: a pending post break fires after an accepting retire
    a_r4_post_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == BS_ARMED && ret_valid && !ret_dslot) |=> brk_req);

endmodule

// File: rtl/ifbrk_top.sv
module ifbrk_top #(
    parameter int AW         = 32,
    parameter int DEPTH      = 4,
    parameter int ALIGN_BITS = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_enable,
    input  logic                     cfg_post,
    input  logic [AW-1:0]            cfg_addr,
    input  logic                     fetch_valid,
    input  logic [AW-1:0]            fetch_addr,
    input  logic                     flush,
    input  logic                     ex_retire,
    input  logic [$clog2(DEPTH)-1:0] ex_tag,
    input  logic                     ex_dslot,
    input  logic                     ex_sleep,
    output logic                     brk_req
);
    logic fetch_hit;
    logic ret_hit;

    ifbrk_match #(
        .AW         (AW),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_match (
        .fetch_addr (fetch_addr),
        .cfg_addr   (cfg_addr),
        .enable     (cfg_enable),
        .hit        (fetch_hit)
    );

    ifbrk_tagq #(
        .DEPTH (DEPTH)
    ) u_tagq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fetch_valid),
        .push_hit (fetch_hit),
        .flush    (flush),
        .pop      (ex_retire),
        .pop_tag  (ex_tag),
        .pop_hit  (ret_hit)
    );

    ifbrk_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .post      (cfg_post),
        .ret_valid (ex_retire),
        .ret_hit   (ret_hit),
        .ret_dslot (ex_dslot),
        .ret_sleep (ex_sleep),
        .brk_req   (brk_req)
    );

    // R1: no request is seen in the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !brk_req);

endmodule

// File: tb/test_ifbrk_top.sv
module test_ifbrk_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_enable;
    logic        cfg_post;
    logic [31:0] cfg_addr;
    logic        fetch_valid;
    logic [31:0] fetch_addr;
    logic        flush;
    logic        ex_retire;
    logic [1:0]  ex_tag;
    logic        ex_dslot;
    logic        ex_sleep;
    logic        brk_req;

    int n_checks = 0;
    int n_fail   = 0;
    logic [1:0] tag_n = 2'd0;

    localparam logic [31:0] A_HIT  = 32'h0000_1002;
    localparam logic [31:0] A_ODD  = 32'h0000_1003;
    localparam logic [31:0] A_MISS = 32'h0000_1000;
    localparam logic [31:0] A_OTH  = 32'h0000_2004;

    always #5 clk = ~clk;

    ifbrk_top #(.AW(32), .DEPTH(4), .ALIGN_BITS(1)) i_ifbrk_top (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_post(cfg_post),
        .cfg_addr(cfg_addr), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .flush(flush), .ex_retire(ex_retire), .ex_tag(ex_tag),
        .ex_dslot(ex_dslot), .ex_sleep(ex_sleep), .brk_req(brk_req)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: brk_req=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic fetch_one(input logic [31:0] a);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        tag_n = tag_n + 2'd1;
    endtask

    task automatic retire(input logic [1:0] t, input logic ds, input logic sl,
                          input logic exp, input string req);
        ex_retire = 1'b1;
        ex_tag    = t;
        ex_dslot  = ds;
        ex_sleep  = sl;
        @(posedge clk);
        @(negedge clk);
        ex_retire = 1'b0;
        ex_dslot  = 1'b0;
        ex_sleep  = 1'b0;
        chk(req, brk_req, exp);
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        tag_n = 2'd0;
    endtask

    task automatic idle_chk(input logic exp, input string req);
        @(posedge clk);
        @(negedge clk);
        chk(req, brk_req, exp);
    endtask

    task automatic t_reset();
        chk("R1 reset", brk_req, 1'b0);
        retire(2'd0, 1'b0, 1'b0, 1'b0, "R1 empty queue");
    endtask

    task automatic t_pre_basic();
        cfg_post = 1'b0;
        do_flush();
        fetch_one(A_HIT);
        fetch_one(A_OTH);
        retire(2'd0, 1'b0, 1'b0, 1'b1, "R3 pre fire");
        idle_chk(1'b0, "R11 single cycle");
        retire(2'd1, 1'b0, 1'b0, 1'b0, "R3 non-match");
    endtask

    task automatic t_align();
        cfg_post = 1'b0;
        do_flush();
        fetch_one(A_ODD);
        fetch_one(A_MISS);
        retire(2'd0, 1'b0, 1'b0, 1'b1, "R2 bit0 ignored");
        idle_chk(1'b0, "R11 gap");
        retire(2'd1, 1'b0, 1'b0, 1'b0, "R2 bit1 differs");
    endtask

    task automatic t_post();
        cfg_post = 1'b1;
        do_flush();
        fetch_one(A_HIT);
        fetch_one(A_OTH);
        fetch_one(A_OTH);
        retire(2'd0, 1'b0, 1'b0, 1'b0, "R4 no fire on target");
        retire(2'd1, 1'b0, 1'b0, 1'b1, "R4 fire on next");
        retire(2'd2, 1'b0, 1'b0, 1'b0, "R11 post one pulse");
    endtask

    task automatic t_post_branch();
        cfg_post = 1'b1;
        do_flush();
        fetch_one(A_HIT);
        fetch_one(A_OTH);
        fetch_one(A_OTH);
        retire(2'd0, 1'b0, 1'b0, 1'b0, "R5 branch retires");
        retire(2'd1, 1'b1, 1'b0, 1'b0, "R5 delay slot holds");
        idle_chk(1'b0, "R5 still waiting");
        retire(2'd2, 1'b0, 1'b0, 1'b1, "R5 fire after slot");
    endtask

    task automatic t_flush();
        cfg_post = 1'b0;
        do_flush();
        fetch_one(A_HIT);
        do_flush();
        retire(2'd0, 1'b0, 1'b0, 1'b0, "R6 flushed tag");
        // fetch and flush in the same cycle
        fetch_valid = 1'b1;
        fetch_addr  = A_HIT;
        flush       = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        flush       = 1'b0;
        tag_n       = 2'd0;
        retire(2'd0, 1'b0, 1'b0, 1'b0, "R6 same-cycle fetch");
        fetch_one(A_OTH);
        retire(2'd0, 1'b0, 1'b0, 1'b0, "R6 tag restart non-match");
    endtask

    task automatic t_tags();
        cfg_post = 1'b0;
        do_flush();
        fetch_one(A_OTH);
        fetch_one(A_OTH);
        fetch_one(A_HIT);
        retire(2'd1, 1'b0, 1'b0, 1'b0, "R7 other tag");
        retire(2'd2, 1'b0, 1'b0, 1'b1, "R7 lookup by tag");
        idle_chk(1'b0, "R11 tag gap");
        retire(2'd2, 1'b0, 1'b0, 1'b0, "R7 slot emptied");
    endtask

    task automatic t_pre_dslot();
        cfg_post = 1'b0;
        do_flush();
        fetch_one(A_HIT);
        fetch_one(A_OTH);
        retire(2'd0, 1'b1, 1'b0, 1'b0, "R8 pre on delay slot");
        retire(2'd1, 1'b0, 1'b0, 1'b0, "R8 nothing pending");
    endtask

    task automatic t_post_sleep();
        cfg_post = 1'b1;
        do_flush();
        fetch_one(A_HIT);
        fetch_one(A_OTH);
        retire(2'd0, 1'b0, 1'b1, 1'b0, "R9 post on sleep");
        retire(2'd1, 1'b0, 1'b0, 1'b0, "R9 nothing pending");
    endtask

    task automatic t_disable();
        cfg_post = 1'b1;
        do_flush();
        fetch_one(A_HIT);
        fetch_one(A_OTH);
        retire(2'd0, 1'b0, 1'b0, 1'b0, "R10 armed");
        cfg_enable = 1'b0;
        idle_chk(1'b0, "R10 disabled");
        cfg_enable = 1'b1;
        retire(2'd1, 1'b0, 1'b0, 1'b0, "R10 armed break discarded");
        cfg_post = 1'b0;
        cfg_enable = 1'b0;
        do_flush();
        fetch_one(A_HIT);
        fetch_one(A_HIT);
        retire(2'd0, 1'b0, 1'b0, 1'b0, "R10 disabled retire");
        cfg_enable = 1'b1;
        retire(2'd1, 1'b0, 1'b0, 1'b0, "R10 unflagged fetch");
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n       = 1'b0;
        cfg_enable  = 1'b1;
        cfg_post    = 1'b0;
        cfg_addr    = A_HIT;
        fetch_valid = 1'b0;
        fetch_addr  = '0;
        flush       = 1'b0;
        ex_retire   = 1'b0;
        ex_tag      = '0;
        ex_dslot    = 1'b0;
        ex_sleep    = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pre_basic();
        t_align();
        t_post();
        t_post_branch();
        t_flush();
        t_tags();
        t_pre_dslot();
        t_post_sleep();
        t_disable();
        summary();
    end

endmodule